// File: doc/BRIEF.md
# Interrupt-to-DMA Request Router

This block steers eight peripheral interrupt causes, the compare-A and compare-B events of four 16-bit timers, either to an intelligent DMA engine or to the normal interrupt path. An 8-bit routing register decides the path for each cause. A byte-wide register bus writes this register and reads it back. When a cause pulses, the block emits a registered one-cycle request on the DMA output or on the interrupt output for that cause. Which one depends on the cause's routing bit.

A mode input selects how bus writes behave. In set-only mode, ones in the write data set routing bits and zeros are ignored. In read/write mode, the written byte replaces the register. The DMA engine reports completions per cause, together with a terminal-count flag and a DMA-side interrupt enable. A completion with both qualifiers set hands the cause back to software: the block clears that routing bit and raises the interrupt for the cause. A clear from a completion takes priority over a bus write to the same bit.

Top module: `irq_dma_router`

## Requirements
- R1: After reset, every routing bit reads 0 and no DMA or interrupt request is asserted.
- R2: Routing bit i serves cause_i[i], dma_req_o[i] and irq_req_o[i]. Bits 7 down to 0 are: timer 4 compare A, timer 4 compare B, timer 3 compare A, timer 3 compare B, timer 2 compare A, timer 2 compare B, timer 1 compare A, timer 1 compare B.
- R3: When cause_i[i] is 1 in a cycle and routing bit i is 1, dma_req_o[i] is 1 in the following cycle and irq_req_o[i] is not raised by that cause.
- R4: When cause_i[i] is 1 in a cycle and routing bit i is 0, irq_req_o[i] is 1 in the following cycle and dma_req_o[i] stays 0.
- R5: With wr_mode_i = 0 (set-only), a write ORs wr_data_i into the register. Written zeros leave bits unchanged.
- R6: With wr_mode_i = 1 (read/write), a write stores wr_data_i as the new register value.
- R7: When dma_done_i[i] is 1 and both dma_tc_i and dma_irq_en_i are 1, routing bit i reads 0 from the next cycle on, and irq_req_o[i] is 1 in the next cycle.
- R8: A completion with dma_tc_i = 0 or dma_irq_en_i = 0 leaves the register unchanged and raises no interrupt.
- R9: When a qualified completion and a bus write that sets bit i occur in the same cycle, bit i ends at 0, in either write mode.
- R10: rd_data_o always shows the current register contents, and reading it has no side effects. Without a write or a qualified completion, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_mode_i | input | 1 | 0 = set-only writes, 1 = read/write |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Current routing register |
| cause_i | input | 8 | Interrupt cause pulses, one per source |
| dma_done_i | input | 8 | DMA transfer completion strobe per cause |
| dma_tc_i | input | 1 | Transfer counter reached zero for the completion |
| dma_irq_en_i | input | 1 | DMA-side interrupt enable for the completion |
| dma_req_o | output | 8 | Registered DMA request pulses |
| irq_req_o | output | 8 | Registered interrupt request pulses |

## Verification
Two events can land on the same bit in the same cycle: a bus write and a qualified DMA completion. The bench drives both in one cycle on the same bit, in read/write mode and in set-only mode. It judges the result by the register read-back in the next cycle and by the interrupt pulse. It also fires a cause on a routed bit in the cycle its completion clears it. In that case the DMA request, which follows the old routing value, and the completion interrupt must both appear in the next cycle.

// File: rtl/irq_dma_router_pkg.sv
package irq_dma_router_pkg;
  typedef enum logic {
    WR_SET_ONLY   = 1'b0,
    WR_READ_WRITE = 1'b1
  } wr_mode_e;

  localparam int unsigned NUM_TIMERS     = 4;
  localparam int unsigned CAUSES_PER_TMR = 2;
  localparam int unsigned DEF_NUM_CAUSES = NUM_TIMERS * CAUSES_PER_TMR;
endpackage

// File: rtl/route_bit.sv
module route_bit
  import irq_dma_router_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_en_i,
  input  logic     wr_bit_i,
  input  wr_mode_e wr_mode_i,
  input  logic     hw_clr_i,
  output logic     q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= 1'b0;
    end else if (hw_clr_i) begin
      q_q <= 1'b0;  // completion clear has priority over bus write
    end else if (wr_en_i) begin
      if (wr_mode_i == WR_READ_WRITE) q_q <= wr_bit_i;
      else                            q_q <= q_q | wr_bit_i;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/req_gen.sv
module req_gen #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] cause_i,
  input  logic [N-1:0] route_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] dma_req_o,
  output logic [N-1:0] irq_req_o
);
  logic [N-1:0] dma_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_q <= '0;
      irq_q <= '0;
    end else begin
      dma_q <= cause_i & route_i;
      irq_q <= (cause_i & ~route_i) | clr_i;
    end
  end

  assign dma_req_o = dma_q;
  assign irq_req_o = irq_q;
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router
  import irq_dma_router_pkg::*;
#(
  parameter int unsigned NUM_CAUSES = DEF_NUM_CAUSES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_mode_i,
  input  logic                  wr_en_i,
  input  logic [NUM_CAUSES-1:0] wr_data_i,
  output logic [NUM_CAUSES-1:0] rd_data_o,
  input  logic [NUM_CAUSES-1:0] cause_i,
  input  logic [NUM_CAUSES-1:0] dma_done_i,
  input  logic                  dma_tc_i,
  input  logic                  dma_irq_en_i,
  output logic [NUM_CAUSES-1:0] dma_req_o,
  output logic [NUM_CAUSES-1:0] irq_req_o
);
  localparam int unsigned W = NUM_CAUSES;

  wr_mode_e     mode;
  logic [W-1:0] route;
  logic [W-1:0] hw_clr;
  logic         done_qual;

  assign mode      = wr_mode_e'(wr_mode_i);
  assign done_qual = dma_tc_i & dma_irq_en_i;
  assign hw_clr    = dma_done_i & {W{done_qual}};

  for (genvar i = 0; i < W; i++) begin : g_bit
    route_bit u_bit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i),
      .wr_bit_i (wr_data_i[i]),
      .wr_mode_i(mode),
      .hw_clr_i (hw_clr[i]),
      .q_o      (route[i])
    );
  end

  req_gen #(.N(W)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cause_i  (cause_i),
    .route_i  (route),
    .clr_i    (hw_clr),
    .dma_req_o(dma_req_o),
    .irq_req_o(irq_req_o)
  );

  assign rd_data_o = route;
endmodule

// File: rtl/irq_dma_router_chk.sv
module irq_dma_router_chk #(
  parameter int unsigned NUM_CAUSES = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_mode_i,
  input logic                  wr_en_i,
  input logic [NUM_CAUSES-1:0] wr_data_i,
  input logic [NUM_CAUSES-1:0] rd_data_o,
  input logic [NUM_CAUSES-1:0] cause_i,
  input logic [NUM_CAUSES-1:0] dma_done_i,
  input logic                  dma_tc_i,
  input logic                  dma_irq_en_i,
  input logic [NUM_CAUSES-1:0] dma_req_o,
  input logic [NUM_CAUSES-1:0] irq_req_o
);
  localparam int unsigned W = NUM_CAUSES;
  logic [W-1:0] clr;
  assign clr = dma_done_i & {W{dma_tc_i & dma_irq_en_i}};

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (rd_data_o == '0 && dma_req_o == '0 && irq_req_o == '0);
    end
  end

  assert_dma_needs_route_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o & ~$past(cause_i & rd_data_o)) == '0);

  assert_irq_has_origin_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o & ~$past(cause_i | clr)) == '0);

  assert_set_only_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) && !$past(wr_mode_i)) |->
      ((($past(rd_data_o) & ~$past(clr)) & ~rd_data_o) == '0));

  assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr) != '0) |-> ((rd_data_o & $past(clr)) == '0));

  assert_clear_raises_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(clr) & ~irq_req_o) == '0));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && clr == '0) |=> $stable(rd_data_o));
endmodule

bind irq_dma_router irq_dma_router_chk #(.NUM_CAUSES(NUM_CAUSES)) u_chk (.*);

// File: tb/sim_irq_dma_router.sv
module sim_irq_dma_router;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_mode_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic [7:0] cause_i = '0;
  logic [7:0] dma_done_i = '0;
  logic       dma_tc_i = 1'b0;
  logic       dma_irq_en_i = 1'b0;
  logic [7:0] dma_req_o;
  logic [7:0] irq_req_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  irq_dma_router u0 (.*);

  typedef struct packed {
    logic [7:0] dma;
    logic [7:0] irq;
    logic [7:0] rd;
  } exp_t;

  exp_t       exp_q[$];
  string      tag_q[$];
  logic [7:0] model = '0;
  int         checks = 0;
  int         errors = 0;
  bit         ended = 0;

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] c, input logic we, input logic [7:0] wd, input logic rw,
                      input logic [7:0] dn, input logic tc, input logic ie, input string tag);
    logic [7:0] clr, nxt;
    exp_t e;
    @(negedge clk_i);
    cause_i = c; wr_en_i = we; wr_data_i = wd; wr_mode_i = rw;
    dma_done_i = dn; dma_tc_i = tc; dma_irq_en_i = ie;
    clr   = dn & {8{tc & ie}};
    nxt   = we ? (rw ? wd : (model | wd)) : model;
    nxt   = nxt & ~clr;
    e.dma = c & model;
    e.irq = (c & ~model) | clr;
    e.rd  = nxt;
    model = nxt;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (rst_ni && exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "dma_req", dma_req_o, e.dma);
        chk(t, "irq_req", irq_req_o, e.irq);
        chk(t, "rd_data", rd_data_o, e.rd);
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #20000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #18;
    chk("R1", "rd_data in reset", rd_data_o, 8'h00);
    chk("R1", "dma_req in reset", dma_req_o, 8'h00);
    chk("R1", "irq_req in reset", irq_req_o, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;

    step(8'h00, 0, 8'h00, 0, 8'h00, 0, 0, "R1");
    step(8'hFF, 0, 8'h00, 0, 8'h00, 0, 0, "R4");
    step(8'h00, 1, 8'hA5, 0, 8'h00, 0, 0, "R5");
    step(8'h00, 1, 8'h00, 0, 8'h00, 0, 0, "R5");
    step(8'h00, 1, 8'h18, 0, 8'h00, 0, 0, "R5");
    step(8'h81, 0, 8'h00, 0, 8'h00, 0, 0, "R3");
    step(8'h80, 0, 8'h00, 0, 8'h00, 0, 0, "R2");
    step(8'h02, 0, 8'h00, 0, 8'h00, 0, 0, "R2");
    step(8'hFF, 0, 8'h00, 0, 8'h00, 0, 0, "R3,R4");
    step(8'h00, 1, 8'h3C, 1, 8'h00, 0, 0, "R6");
    step(8'h00, 1, 8'h00, 1, 8'h00, 0, 0, "R6");
    step(8'h00, 1, 8'hFF, 1, 8'h00, 0, 0, "R6");
    step(8'h00, 0, 8'h00, 0, 8'h10, 1, 1, "R7");
    step(8'h10, 0, 8'h00, 0, 8'h00, 0, 0, "R7");
    step(8'h00, 0, 8'h00, 0, 8'h01, 0, 1, "R8");
    step(8'h00, 0, 8'h00, 0, 8'h01, 1, 0, "R8");
    step(8'h00, 1, 8'hFF, 1, 8'h02, 1, 1, "R9");
    step(8'h00, 1, 8'h02, 0, 8'h02, 1, 1, "R9");
    step(8'h04, 0, 8'h00, 0, 8'h04, 1, 1, "R7,R9");
    for (int k = 0; k < 4; k++) step(8'h00, 0, 8'h00, 0, 8'h00, 0, 0, "R10");
    for (int k = 0; k < 200; k++)
      step($urandom, $urandom_range(0, 1) == 0, $urandom, $urandom_range(0, 1) == 1,
           ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00,
           $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, "R3,R4,R5,R6,R7,R8,R9,R10");
    @(negedge clk_i);
    cause_i = '0; wr_en_i = 0; dma_done_i = '0;
    @(posedge clk_i); #3;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL queue: actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule